// File: doc/BRIEF.md
# Vector String Isolation Unit

This execution unit takes a 128-bit vector operand and treats it as a string of 8-, 16- or 32-bit elements. Element 0 occupies the most significant end. The unit looks for the first element whose bits are all zero and treats it as the string terminator. That element and every element after it (toward the least significant end) come out as zero. The elements before it pass through unchanged. When no element is zero, the operand passes through whole.

A one-cycle `start_i` pulse launches an operation. On the next cycle the unit presents, in the same cycle:

- the result;
- a result-valid pulse;
- an optional condition code with its write strobe;
- a specification-exception flag.

The condition code reports whether a terminator was found. It is produced only when the low bit of the modifier field asks for it. An illegal element-size code or modifier value suppresses the result and raises the exception flag instead.

Top module: `strisol_unit`

## Requirements
- R1: `esize_i` selects the element width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits. The value 3 is illegal and raises `spec_exc_o`.
- R2: Only bit 0 of `mod_i` is defined. A start with any of `mod_i[3:1]` set raises `spec_exc_o`.
- R3: For an illegal start, `spec_exc_o` pulses one cycle later. For that operation `result_valid_o` and `cc_we_o` stay low, and `result_o` and `cc_o` keep their previous values.
- R4: Element 0 is `src_i[127 -: w]` and later elements follow toward bit 0. The first all-zero element, and all bits below it, read as zero in `result_o`. All bits above it are copied from `src_i`. In particular, a terminator in the upper 64 bits clears the whole lower 64 bits.
- R5: An element counts as a terminator only when all of its bits at the selected width are zero. A zero byte inside a non-zero 16- or 32-bit element is not a terminator.
- R6: When a terminator exists, the condition code value is 0. When none exists, the value is 3 and `result_o` equals `src_i`.
- R7: `cc_we_o` pulses and `cc_o` is updated only for a legal start with `mod_i[0]` = 1. Otherwise `cc_o` holds its value.
- R8: `result_o`, `cc_o`, `cc_we_o`, `result_valid_o` and `spec_exc_o` appear together on the cycle after the `start_i` cycle. Without a start, the three strobes are low.
- R9: After synchronous reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle operation launch |
| src_i | input | 128 | Source vector operand |
| esize_i | input | 2 | Element size code |
| mod_i | input | 4 | Modifier field, bit 0 requests condition code |
| result_o | output | 128 | Isolated string result |
| result_valid_o | output | 1 | Result-valid pulse |
| cc_o | output | 2 | Condition code (0 found, 3 none) |
| cc_we_o | output | 1 | Condition-code write strobe |
| spec_exc_o | output | 1 | Specification-exception pulse |

## Verification
Three events can coincide in one launch: the terminator search, the condition-code update and operand validation. Of these, validation must win over the other two. The bench provokes this by sending starts with `mod_i[0]` set together with an illegal size or an illegal upper modifier bit. It picks operands that contain a terminator, so a wrongly written result or condition code would be visible. It then checks that the exception pulses alone, while `result_o` and `cc_o` still show the previous legal operation. Legal starts with and without `mod_i[0]` alternate, to separate a result write from a condition-code write.

// File: rtl/strisol_pkg.sv
package strisol_pkg;

    localparam int STR_VEC_W  = 128;
    localparam int STR_BYTE_W = 8;
    localparam int STR_MOD_W  = 4;

    typedef enum logic [1:0] {
        ESZ_8   = 2'd0,
        ESZ_16  = 2'd1,
        ESZ_32  = 2'd2,
        ESZ_BAD = 2'd3
    } esize_e;

    localparam logic [1:0] CC_TERM_FOUND = 2'd0;
    localparam logic [1:0] CC_NO_TERM    = 2'd3;

    typedef struct packed {
        logic [STR_VEC_W-1:0] data;
        logic                 found;
    } iso_out_t;

    function automatic logic op_legal(input logic [1:0] esz,
                                      input logic [STR_MOD_W-1:0] mod);
        return (esize_e'(esz) != ESZ_BAD) && (mod[STR_MOD_W-1:1] == '0);
    endfunction

endpackage

// File: rtl/strisol_elem_zero.sv
module strisol_elem_zero
    import strisol_pkg::*;
#(
    parameter int VEC_W  = STR_VEC_W,
    parameter int BYTE_W = STR_BYTE_W,
    localparam int NBYTE = VEC_W / BYTE_W
) (
    input  logic [VEC_W-1:0] data_i,
    input  logic [1:0]       esize_i,
    output logic [NBYTE-1:0] hit_o
);

    logic [NBYTE-1:0] z8;
    logic [NBYTE-1:0] z16;
    logic [NBYTE-1:0] z32;

    // Each byte lane carries the zero flag of the element that contains it.
    for (genvar i = 0; i < NBYTE; i++) begin : g_lane
        localparam int HB = (i / 2) * 2;
        localparam int WB = (i / 4) * 4;
        assign z8[i]  = ~|data_i[i*BYTE_W +: BYTE_W];
        assign z16[i] = z8[HB] & z8[HB+1];
        assign z32[i] = &z8[WB +: 4];
    end

    always_comb begin
        case (esize_e'(esize_i))
            ESZ_8:   hit_o = z8;
            ESZ_16:  hit_o = z16;
            ESZ_32:  hit_o = z32;
            default: hit_o = '0;
        endcase
    end

endmodule

// File: rtl/strisol_prefix_mask.sv
module strisol_prefix_mask
    import strisol_pkg::*;
#(
    parameter int VEC_W  = STR_VEC_W,
    parameter int BYTE_W = STR_BYTE_W,
    localparam int NBYTE = VEC_W / BYTE_W
) (
    input  logic [VEC_W-1:0] data_i,
    input  logic [NBYTE-1:0] hit_i,
    output iso_out_t         iso_o
);

    // clr[i] is set once any lane at or above i (toward element 0) hit.
    logic [NBYTE-1:0] clr;

    assign clr[NBYTE-1] = hit_i[NBYTE-1];
    for (genvar i = NBYTE - 2; i >= 0; i--) begin : g_scan
        assign clr[i] = clr[i+1] | hit_i[i];
    end

    for (genvar i = 0; i < NBYTE; i++) begin : g_out
        assign iso_o.data[i*BYTE_W +: BYTE_W] =
            clr[i] ? '0 : data_i[i*BYTE_W +: BYTE_W];
    end

    assign iso_o.found = clr[0];

endmodule

// File: rtl/strisol_unit.sv
module strisol_unit
    import strisol_pkg::*;
#(
    parameter int VEC_W  = STR_VEC_W,
    parameter int BYTE_W = STR_BYTE_W,
    parameter int MOD_W  = STR_MOD_W,
    localparam int NBYTE = VEC_W / BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [VEC_W-1:0] src_i,
    input  logic [1:0]       esize_i,
    input  logic [MOD_W-1:0] mod_i,
    output logic [VEC_W-1:0] result_o,
    output logic             result_valid_o,
    output logic [1:0]       cc_o,
    output logic             cc_we_o,
    output logic             spec_exc_o
);

    logic [NBYTE-1:0] hit;
    iso_out_t         iso;
    logic             legal;
    logic             go;

    strisol_elem_zero #(.VEC_W(VEC_W), .BYTE_W(BYTE_W)) i_zero (
        .data_i  (src_i),
        .esize_i (esize_i),
        .hit_o   (hit)
    );

    strisol_prefix_mask #(.VEC_W(VEC_W), .BYTE_W(BYTE_W)) i_mask (
        .data_i (src_i),
        .hit_i  (hit),
        .iso_o  (iso)
    );

    assign legal = op_legal(esize_i, mod_i);
    assign go    = start_i & legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o       <= '0;
            result_valid_o <= 1'b0;
            cc_o           <= 2'd0;
            cc_we_o        <= 1'b0;
            spec_exc_o     <= 1'b0;
        end else begin
            result_valid_o <= go;
            cc_we_o        <= go & mod_i[0];
            spec_exc_o     <= start_i & ~legal;
            if (go) begin
                result_o <= iso.data;
            end
            if (go && mod_i[0]) begin
                cc_o <= iso.found ? CC_TERM_FOUND : CC_NO_TERM;
            end
        end
    end

    AST_EXC_SUPPRESSES: assert property (@(posedge clk) disable iff (rst)
        spec_exc_o |-> (!result_valid_o && !cc_we_o)); // R3
    AST_BAD_SIZE_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (start_i && esize_i == 2'd3) |=> spec_exc_o); // R1
    AST_BAD_MOD_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (start_i && mod_i[MOD_W-1:1] != '0) |=> spec_exc_o); // R2
    AST_NONE_PASSES_SRC: assert property (@(posedge clk) disable iff (rst)
        (cc_we_o && cc_o == CC_NO_TERM) |-> result_o == $past(src_i)); // R6
    AST_CCWE_NEEDS_MOD: assert property (@(posedge clk) disable iff (rst)
        cc_we_o |-> $past(mod_i[0])); // R7
    AST_CC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cc_we_o |-> $stable(cc_o)); // R7
    AST_ONE_CYCLE_LATE: assert property (@(posedge clk) disable iff (rst)
        (result_valid_o || spec_exc_o) |-> $past(start_i)); // R8

endmodule

// File: tb/test_strisol_unit.sv
module test_strisol_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         start_i;
    logic [127:0] src_i;
    logic [1:0]   esize_i;
    logic [3:0]   mod_i;
    logic [127:0] result_o;
    logic         result_valid_o;
    logic [1:0]   cc_o;
    logic         cc_we_o;
    logic         spec_exc_o;

    int checks = 0;
    int errors = 0;
    logic [127:0] exp_res = '0;
    logic [1:0]   exp_cc = 2'd0;

    always #5 clk = ~clk;

    strisol_unit i_strisol_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .src_i(src_i),
        .esize_i(esize_i), .mod_i(mod_i), .result_o(result_o),
        .result_valid_o(result_valid_o), .cc_o(cc_o), .cc_we_o(cc_we_o),
        .spec_exc_o(spec_exc_o)
    );

    task automatic chk(input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: walk elements from the top, clear from the first zero one down.
    function automatic logic [128:0] model(input logic [127:0] s, input int es);
        int w = 8 << es;
        logic [127:0] r = s;
        for (int e = 0; e < 128 / w; e++) begin
            logic z = 1'b1;
            for (int b = 0; b < w; b++) if (s[127 - e*w - b]) z = 1'b0;
            if (z) begin
                for (int i = 0; i <= 127 - e*w; i++) r[i] = 1'b0;
                return {1'b1, r};
            end
        end
        return {1'b0, r};
    endfunction

    function automatic logic [127:0] clear_elem(input logic [127:0] v,
                                                 input int es, input int idx);
        int w = 8 << es;
        for (int b = 0; b < w; b++) v[127 - idx*w - b] = 1'b0;
        return v;
    endfunction

    function automatic logic [127:0] no_zero(input logic [127:0] v, input int es);
        int w = 8 << es;
        for (int e = 0; e < 128 / w; e++) v[127 - e*w - (w-1)] = 1'b1;
        return v;
    endfunction

    task automatic run_op(input logic [127:0] s, input int es, input logic [3:0] m,
                          input string tag);
        logic legal;
        logic [128:0] mr;
        legal = (es != 3) && (m[3:1] == 3'b0);
        @(negedge clk);
        start_i = 1'b1; src_i = s; esize_i = es[1:0]; mod_i = m;
        @(negedge clk);
        start_i = 1'b0;
        if (legal) begin
            mr = model(s, es);
            exp_res = mr[127:0];
            if (m[0]) exp_cc = mr[128] ? 2'd0 : 2'd3;
        end
        chk({tag, " R8 valid"}, {127'b0, result_valid_o}, {127'b0, legal});
        chk({tag, " R3 exc"}, {127'b0, spec_exc_o}, {127'b0, !legal});
        chk({tag, " R7 cc_we"}, {127'b0, cc_we_o}, {127'b0, legal && m[0]});
        chk({tag, " R4 result"}, result_o, exp_res);
        chk({tag, " R6 cc"}, {126'b0, cc_o}, {126'b0, exp_cc});
        @(negedge clk);
        chk({tag, " R8 idle strobes"}, {125'b0, result_valid_o, cc_we_o, spec_exc_o}, '0);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] ones;
        logic [127:0] v;
        void'($urandom(32'd1234));
        ones = '1;
        rst = 1'b1; start_i = 1'b0; src_i = '0; esize_i = '0; mod_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9 reset outputs",
            {result_o[124:0], cc_o, result_valid_o} | {125'b0, cc_we_o, spec_exc_o, 1'b0}, '0);
        chk("R9 reset result", result_o, '0);

        for (int es = 0; es < 3; es++) begin
            run_op(clear_elem(ones, es, 0), es, 4'd1, "R1 first elem");
            run_op(clear_elem(ones, es, 128/(8<<es) - 1), es, 4'd1, "R1 last elem");
            run_op(clear_elem(ones, es, 1), es, 4'd1, "R4 upper half");
            run_op(clear_elem(ones, es, 64/(8<<es) + 1), es, 4'd1, "R4 lower half");
            run_op('0, es, 4'd1, "R4 all zero");
            run_op(no_zero(128'h0123_4567_89ab_cdef_0000_1111_2222_3333, es), es, 4'd1,
                   "R6 none");
            run_op(clear_elem(ones, es, 2), es, 4'd0, "R7 no cc");
        end
        run_op({8{16'h00ff}}, 1, 4'd1, "R5 byte zero in half");
        run_op({4{32'h0000_00ff}}, 2, 4'd1, "R5 byte zero in word");
        run_op({4{32'h0000_00ff}}, 0, 4'd1, "R5 byte mode");
        run_op(clear_elem(ones, 0, 3), 3, 4'd1, "R1 bad size");
        run_op(clear_elem(ones, 0, 3), 0, 4'd2, "R2 bad mod1");
        run_op(clear_elem(ones, 0, 3), 1, 4'd4, "R2 bad mod2");
        run_op(clear_elem(ones, 0, 3), 2, 4'd9, "R2 bad mod3");

        for (int n = 0; n < 300; n++) begin
            int es = $urandom_range(0, 3);
            int sel = $urandom_range(0, 9);
            logic [3:0] m = (sel == 0) ? 4'($urandom_range(0, 15)) : {3'b0, 1'($urandom)};
            int esz = (es == 3) ? 0 : es;
            v = {$urandom, $urandom, $urandom, $urandom};
            if (sel > 2) v = no_zero(v, esz);
            if (sel > 5) v = clear_elem(v, esz, $urandom_range(0, 128/(8<<esz) - 1));
            if (sel == 1) v = v & {16{8'($urandom_range(0, 1) ? 8'h00 : 8'hff)}};
            run_op(v, (es == 3 && sel > 1) ? 2 : es, m, "R4 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule